// File: doc/BRIEF.md
# Serial Flash Fast-Read Responder

This block is the device side of a serial-flash read path. A host lowers chip select and clocks in an 8-bit read opcode, a 24-bit byte address and one dummy byte, all serially on IO0. The block then returns the contents of an external byte-wide memory, starting at that address and advancing one byte at a time, for as long as chip select stays low. Three opcodes are recognised, and they differ only in how many IO lines carry the returned data: one line (0Bh), two lines (3Bh) or four lines (6Bh).

The serial clock, chip select and IO0 come from the host and are oversampled by a faster system clock `clk` through a synchronizer chain. Rising serial-clock edges sample command bits. Falling edges advance the output data. The memory sits outside the block and is reached through a request/response port: `mem_rd` pulses for one `clk` cycle with `mem_addr`, and `mem_rdata` must be valid on the following cycle. The block prefetches one byte ahead, so the next byte is already held when its first output edge arrives. Output values and per-line output enables are registered and are meant to drive tri-state pads.

Top module: `flash_read_engine`

## Requirements
- R1: Opcode, address and dummy bits are sampled from IO0 on rising serial-clock edges, most significant bit first. The opcode takes 8 clocks, the address 24 clocks (A23 first) and the dummy byte 8 clocks.
- R2: All four output enables stay low from the fall of chip select until the first falling edge after the last dummy bit.
- R3: Opcode 0Bh returns each byte MSB first, one bit per clock, on line 1 only, with output-enable pattern 0010b.
- R4: Opcode 3Bh returns two bits per clock, with line 1 carrying bits 7,5,3,1 and line 0 carrying bits 6,4,2,0, with output-enable pattern 0011b.
- R5: Opcode 6Bh returns four bits per clock, with lines 3..0 carrying bits 7..4 on the first clock and bits 3..0 on the second, with output-enable pattern 1111b.
- R6: Output values change only after a falling serial-clock edge and are held across the rising edge.
- R7: The first byte may sit at any address, and each following byte comes from the next higher address, without limit while chip select is low.
- R8: The byte address wraps from FFFFFFh to 000000h.
- R9: Raising chip select clears all output enables at once and returns the block to waiting for an opcode. A partly shifted byte is dropped, and the next transaction starts cleanly.
- R10: An opcode other than 0Bh, 3Bh or 6Bh leaves all output enables low and issues no memory request until chip select rises.
- R11: Each memory request is a single-cycle `mem_rd` pulse. The first request is issued once the last address bit is sampled. One further request is issued as each returned byte begins shifting out, so reading N bytes issues N+1 requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial interface |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_io0_in | input | 1 | Serial command and address input (IO0 pad input) |
| spi_io_out | output | 4 | Output values for IO3..IO0 |
| spi_io_oe | output | 4 | Per-line output enables for IO3..IO0 |
| mem_rd | output | 1 | One-cycle memory read request |
| mem_addr | output | 24 | Byte address of the request |
| mem_rdata | input | 8 | Memory data, valid the cycle after `mem_rd` |

## Verification
On every cycle, the bound checker enforces these properties: the output enables stay low outside the data phase and take only the three legal patterns; the output values stay put except after a falling serial edge; chip select releases the enables; requests are single pulses; and each request within a transaction names the address one higher than the previous request. Several behaviours are visible only through the bench's scenarios: the correct lane-to-bit mapping for each width, returned data matching the addressed bytes across a sweep of start addresses, wrap-around at the top of the address space, recovery after an aborted byte, and silence after an unknown opcode.

// File: rtl/frd_pkg.sv
package frd_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_IGNORE
  } phase_t;

  typedef enum logic [1:0] {
    LW_1,
    LW_2,
    LW_4
  } lanes_t;

  // output-enable pattern for each data width
  function automatic logic [3:0] oe_mask(input lanes_t w);
    case (w)
      LW_2:    return 4'b0011;
      LW_4:    return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction

  // index of the last slice of a byte (slices per byte minus one)
  function automatic logic [2:0] last_slice(input lanes_t w);
    case (w)
      LW_2:    return 3'd3;
      LW_4:    return 3'd1;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/frd_edge_sync.sv
module frd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic si,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_n_s,
  output logic si_s
);

  // {cs_n, sclk, si} through the synchronizer chain
  logic [2:0] stg [STAGES];
  logic       sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= 3'b100;
      sclk_q <= 1'b0;
    end else begin
      stg[0] <= {cs_n, sclk, si};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sclk_q <= stg[STAGES-1][1];
    end
  end

  assign cs_n_s    = stg[STAGES-1][2];
  assign si_s      = stg[STAGES-1][0];
  assign sclk_rise =  stg[STAGES-1][1] & ~sclk_q;
  assign sclk_fall = ~stg[STAGES-1][1] &  sclk_q;

endmodule

// File: rtl/frd_serializer.sv
module frd_serializer
  import frd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       step,
  input  lanes_t     lanes,
  input  logic [7:0] byte_in,
  output logic       take,
  output logic [3:0] io_out
);

  logic [7:0] sh;
  logic [2:0] rem;
  logic [7:0] cur;

  assign take = (rem == 3'd0);
  assign cur  = take ? byte_in : sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      rem    <= '0;
      io_out <= '0;
    end else if (abort) begin
      rem <= '0;
    end else if (step) begin
      case (lanes)
        LW_2: begin
          io_out <= {2'b00, cur[7], cur[6]};
          sh     <= {cur[5:0], 2'b00};
        end
        LW_4: begin
          io_out <= cur[7:4];
          sh     <= {cur[3:0], 4'b0000};
        end
        default: begin
          io_out <= {2'b00, cur[7], 1'b0};
          sh     <= {cur[6:0], 1'b0};
        end
      endcase
      rem <= take ? last_slice(lanes) : rem - 3'd1;
    end
  end

endmodule

// File: rtl/flash_read_engine.sv
module flash_read_engine
  import frd_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int          SYNC_STAGES = 2,
  parameter int          DUMMY_CLKS  = 8,
  parameter logic [7:0]  OP_X1       = 8'h0B,
  parameter logic [7:0]  OP_X2       = 8'h3B,
  parameter logic [7:0]  OP_X4       = 8'h6B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_io0_in,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);

  localparam int CNT_MAX = (ADDR_W > DUMMY_CLKS) ? ADDR_W : DUMMY_CLKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] OPC_LAST   = CNT_W'(7);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CLKS - 1);

  logic              sclk_rise, sclk_fall, cs_n_s, si_s;
  phase_t            phase;
  lanes_t            lanes;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        cmd_sr;
  logic [ADDR_W-1:0] addr_sr;
  logic [ADDR_W-1:0] next_addr;
  logic              rd_pend;
  logic [7:0]        byte_buf;
  logic [7:0]        opc_next;
  logic [ADDR_W-1:0] addr_full;
  logic              step, take;

  frd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .si        (spi_io0_in),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_n_s    (cs_n_s),
    .si_s      (si_s)
  );

  assign opc_next  = {cmd_sr[6:0], si_s};
  assign addr_full = {addr_sr[ADDR_W-2:0], si_s};
  assign step      = ~cs_n_s & sclk_fall & (phase == PH_DATA);

  frd_serializer u_ser (
    .clk     (clk),
    .rst     (rst),
    .abort   (cs_n_s),
    .step    (step),
    .lanes   (lanes),
    .byte_in (byte_buf),
    .take    (take),
    .io_out  (spi_io_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_OPC;
      lanes     <= LW_1;
      cnt       <= '0;
      cmd_sr    <= '0;
      addr_sr   <= '0;
      next_addr <= '0;
      rd_pend   <= 1'b0;
      byte_buf  <= '0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
      spi_io_oe <= '0;
    end else begin
      mem_rd  <= 1'b0;
      rd_pend <= mem_rd;
      if (rd_pend) byte_buf <= mem_rdata;

      if (cs_n_s) begin
        phase     <= PH_OPC;
        cnt       <= '0;
        spi_io_oe <= '0;
      end else begin
        if (sclk_rise) begin
          case (phase)
            PH_OPC: begin
              cmd_sr <= opc_next;
              if (cnt == OPC_LAST) begin
                cnt <= '0;
                case (opc_next)
                  OP_X1: begin lanes <= LW_1; phase <= PH_ADDR; end
                  OP_X2: begin lanes <= LW_2; phase <= PH_ADDR; end
                  OP_X4: begin lanes <= LW_4; phase <= PH_ADDR; end
                  default: phase <= PH_IGNORE;
                endcase
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_ADDR: begin
              addr_sr <= addr_full;
              if (cnt == ADDR_LAST) begin
                cnt       <= '0;
                phase     <= PH_DUMMY;
                mem_rd    <= 1'b1;
                mem_addr  <= addr_full;
                next_addr <= addr_full + 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_DUMMY: begin
              if (cnt == DUMMY_LAST) begin
                cnt   <= '0;
                phase <= PH_DATA;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (step) begin
          spi_io_oe <= oe_mask(lanes);
          if (take) begin
            mem_rd    <= 1'b1;
            mem_addr  <= next_addr;
            next_addr <= next_addr + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/frd_checker.sv
module frd_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n_s,
  input logic              fall,
  input logic              in_data,
  input logic [3:0]        io_oe,
  input logic [3:0]        io_out,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr
);

  logic [ADDR_W-1:0] last_addr;
  logic              seen;

  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      seen      <= 1'b0;
      last_addr <= '0;
    end else if (mem_rd) begin
      seen      <= 1'b1;
      last_addr <= mem_addr;
    end
  end

  // R2
  oe_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (|io_oe) |-> in_data);

  // R3 R4 R5
  oe_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    (io_oe == 4'b0000) || (io_oe == 4'b0010) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(io_out));

  // R9
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (io_oe == 4'b0000));

  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && seen && !cs_n_s) |-> (mem_addr == last_addr + 1'b1));

endmodule

bind flash_read_engine frd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n_s   (cs_n_s),
  .fall     (sclk_fall),
  .in_data  (phase == frd_pkg::PH_DATA),
  .io_oe    (spi_io_oe),
  .io_out   (spi_io_out),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr)
);

// File: tb/flash_read_engine_tb.sv
module flash_read_engine_tb;

  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_io0_in = 1'b0;
  logic [3:0]  spi_io_out, spi_io_oe;
  logic        mem_rd;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0;
  int fails  = 0;
  int rd_cnt = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  flash_read_engine u_dut (
    .clk        (clk),
    .rst        (rst),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_io0_in (spi_io0_in),
    .spi_io_out (spi_io_out),
    .spi_io_oe  (spi_io_oe),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ (a[23:16] + 8'h3C);
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= pat(mem_addr);
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one serial clock: low half (drive IO0, sample), then high half (sample again)
  task automatic bit_cycle(input logic b, output logic [3:0] o, output logic [3:0] e,
                           output logic [3:0] o_hi);
    spi_sclk   = 1'b0;
    spi_io0_in = b;
    repeat (H) @(negedge clk);
    o = spi_io_out;
    e = spi_io_oe;
    spi_sclk = 1'b1;
    repeat (H) @(negedge clk);
    o_hi = spi_io_out;
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [23:0] a, output logic [3:0] oe_or);
    logic [39:0] bits;
    logic [3:0]  o, e, oh;
    bits  = {op, a, 8'h00};
    oe_or = 4'b0000;
    spi_cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 39; i >= 0; i--) begin
      bit_cycle(bits[i], o, e, oh);
      oe_or = oe_or | e;
    end
  endtask

  task automatic end_cmd();
    spi_sclk = 1'b0;
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 enables released", {28'd0, spi_io_oe}, 32'd0);
  endtask

  task automatic read_bytes(input int lanes, input logic [23:0] a, input int n, input string req);
    logic [3:0] o, e, oh;
    logic [7:0] v;
    logic [3:0] mask;
    mask = (lanes == 1) ? 4'b0010 : (lanes == 2) ? 4'b0011 : 4'b1111;
    for (int k = 0; k < n; k++) begin
      v = 8'h00;
      for (int s = 0; s < 8 / lanes; s++) begin
        bit_cycle(1'b0, o, e, oh);
        if (lanes == 1)      v = {v[6:0], o[1]};
        else if (lanes == 2) v = {v[5:0], o[1], o[0]};
        else                 v = {v[3:0], o[3:0]};
        if (s == 0) begin
          chk({req, " enable pattern"}, {28'd0, e}, {28'd0, mask});
          chk("R6 held across rising edge", {28'd0, oh}, {28'd0, o});
        end
      end
      // R1 R7: data follows the serially supplied address, one up per byte
      chk({req, " R7 data byte"}, {24'd0, v}, {24'd0, pat(a + 24'(k))});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [3:0]  oe_or;
    logic [23:0] addrs [5];
    logic [7:0]  ops [3];
    int          lw [3];
    string       tags [3];
    int          r0;
    addrs = '{24'h000000, 24'h000001, 24'h12345A, 24'h7FFFFE, 24'hABCDEF};
    ops   = '{8'h0B, 8'h3B, 8'h6B};
    lw    = '{1, 2, 4};
    tags  = '{"R3", "R4", "R5"};

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 reset enables", {28'd0, spi_io_oe}, 32'd0);
    chk("R11 reset request", {31'd0, mem_rd}, 32'd0);

    // sweep of widths and start addresses
    for (int m = 0; m < 3; m++) begin
      for (int j = 0; j < 5; j++) begin
        r0 = rd_cnt;
        send_cmd(ops[m], addrs[j], oe_or);
        chk("R2 R1 quiet command phase", {28'd0, oe_or}, 32'd0);
        read_bytes(lw[m], addrs[j], 4, tags[m]);
        end_cmd();
        chk("R11 request count", rd_cnt - r0, 32'd5);
      end
    end

    // wrap at the top of the address space
    for (int m = 0; m < 3; m++) begin
      send_cmd(ops[m], 24'hFFFFFE, oe_or);
      read_bytes(lw[m], 24'hFFFFFE, 4, "R8 wrap");
      end_cmd();
    end

    // abort in the middle of a byte, then restart
    begin
      logic [3:0] o, e, oh;
      send_cmd(8'h6B, 24'h000100, oe_or);
      bit_cycle(1'b0, o, e, oh);
      chk("R9 partial byte started", {28'd0, e}, 32'hF);
      end_cmd();
      send_cmd(8'h0B, 24'h000200, oe_or);
      chk("R9 clean restart quiet", {28'd0, oe_or}, 32'd0);
      read_bytes(1, 24'h000200, 2, "R9 R3");
      end_cmd();
    end

    // unknown opcodes are ignored
    for (int q = 0; q < 2; q++) begin
      logic [3:0] o, e, oh;
      logic [3:0] extra_oe;
      r0 = rd_cnt;
      send_cmd((q == 0) ? 8'h03 : 8'hBB, 24'h000040, oe_or);
      extra_oe = 4'b0000;
      for (int s = 0; s < 16; s++) begin
        bit_cycle(1'b1, o, e, oh);
        extra_oe = extra_oe | e;
      end
      chk("R10 no enables", {28'd0, oe_or | extra_oe}, 32'd0);
      chk("R10 no requests", rd_cnt - r0, 32'd0);
      end_cmd();
    end

    // a valid command right after an ignored one
    send_cmd(8'h3B, 24'h00ABCD, oe_or);
    read_bytes(2, 24'h00ABCD, 2, "R10 R4 recovery");
    end_cmd();

    done = 1'b1;
    report();
  end

endmodule